// File: doc/BRIEF.md
# Streaming Packet CRC-16 Checker and Maintenance Hop Rewriter

This block sits in the forwarding path of a switch port. Packets arrive as 32-bit words with start and end markers. Each word leaves the block two cycles after it enters. While a packet passes, the block checks its 16-bit CRC fields. A long packet carries one CRC field at a fixed byte offset and a second CRC field at its end. A short packet carries only the end field. The block reports a mismatch at either field with the last word of that packet.

Ordinary packets leave bit-exact, CRC fields included. Because of this, corruption that happens anywhere inside the switch can still be seen further downstream.

Maintenance packets are recognised by a type code in their first word. The block decrements their hop count and rebuilds both CRC fields over the bytes it sends out. A maintenance packet that arrives with a hop count of zero is not forwarded: the block removes it and raises a one-cycle drop indication.

The words of one packet must arrive on consecutive cycles. The input may go idle between packets. A maintenance packet is at least two words long.

Top module: `pktcrc_fwd`

## Requirements
- R1: While reset is held, and in the first cycle after it, `outValid` and `hopDrop` are low.
- R2: Every word that is not dropped appears on the output exactly two cycles after it is sampled. Words keep their order and their start and end markers.
- R3: A packet whose type code is not the maintenance code is forwarded with every bit unchanged, CRC fields included.
- R4: The end CRC field is bits [15:0] of the word that carries the end marker. It must equal the CRC-16 computed over every byte of the packet that precedes it. The CRC uses polynomial 0x1021, MSB first, with a preset of 0xFFFF, and bytes are taken from bits [31:24] down to [7:0] of each word. A mismatch sets `outCrcErr` together with that packet's last output word.
- R5: When a packet has more than IMM_BYTES/4 words, bits [31:16] of word number IMM_BYTES/4 (the first word is word 0) hold an intermediate CRC. This is the same CRC computed over all bytes of the words before it. A mismatch sets `outCrcErr` on that packet's last word.
- R6: The intermediate CRC field is itself included in the running CRC that the end field is checked against.
- R7: A packet of IMM_BYTES/4 words or fewer has no intermediate field. In such a packet, every bit outside the end field is plain data.
- R8: A packet is a maintenance packet exactly when bits [3:0] of its first word equal 4'h8. Any other value is an ordinary packet, whatever its hop byte holds.
- R9: In a forwarded maintenance packet, the hop count in bits [31:24] of word 1 leaves decremented by one.
- R10: In a forwarded maintenance packet, both CRC fields are regenerated over the outgoing bytes. `outCrcErr` still reports any mismatch in the incoming fields.
- R11: A maintenance packet whose incoming hop count is zero produces no output words. It raises `hopDrop` for exactly one cycle.
- R12: `outCrcErr` is high only with a valid end-marked word. An error in one packet has no effect on the flag of the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word present |
| inSop | input | 1 | First word of a packet |
| inEop | input | 1 | Last word of a packet |
| inData | input | 32 | Input word |
| outValid | output | 1 | Output word present |
| outSop | output | 1 | First word of a forwarded packet |
| outEop | output | 1 | Last word of a forwarded packet |
| outData | output | 32 | Output word |
| outCrcErr | output | 1 | CRC mismatch in this packet, valid with the last word |
| hopDrop | output | 1 | One-cycle pulse when a maintenance packet with hop count zero is removed |

## Verification
The bench builds the block with IMM_BYTES set to 16, which places the intermediate field in word 4. With that setting, packets of five to seven words cover both CRC positions, and a four-word packet falls exactly on the boundary of R7. Kind and hop placement keep their default positions. The bench therefore sends maintenance packets with hop counts of zero, one and five, and corrupts single bits in the data, in the intermediate field and in the end field.

// File: rtl/pktcrc_pkg.sv
package pktcrc_pkg;

  // Strobes from the control half to the datapath, one set per input word
  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
    logic immPos;   // word carries the intermediate CRC in its upper half
    logic hopPos;   // word carries the hop count
    logic maint;    // word belongs to a maintenance packet
    logic dropNow;  // hop count zero seen: discard the packet
    logic kill;     // this word must not enter the pipeline
  } ctrlStrobes_t;

  // CRC-16, polynomial 0x1021, MSB first, 16 data bits per call
  function automatic logic [15:0] crcStep16(input logic [15:0] seed, input logic [15:0] d);
    logic [15:0] c;
    logic fb;
    c = seed;
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

endpackage

// File: rtl/pktcrc_ctrl.sv
module pktcrc_ctrl
  import pktcrc_pkg::*;
#(
  parameter int IMM_WORD   = 20,
  parameter int KIND_W     = 4,
  parameter int KIND_MAINT = 8,
  parameter int HOP_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [KIND_W-1:0] kindField,
  input  logic [HOP_W-1:0]  hopField,
  output ctrlStrobes_t      strb
);

  localparam int CNT_W = $clog2(IMM_WORD + 2);
  localparam logic [CNT_W-1:0] IMM_IDX = CNT_W'(IMM_WORD);
  localparam logic [CNT_W-1:0] SAT_IDX = CNT_W'(IMM_WORD + 1);
  localparam logic [CNT_W-1:0] HOP_IDX = CNT_W'(1);

  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] wordIdx;
  logic pktMaint;
  logic dropActive;
  logic kindMaint;
  logic maintNow;
  logic dropNow;

  assign wordIdx   = inSop ? '0 : wordCnt;
  assign kindMaint = (kindField == KIND_W'(KIND_MAINT));
  assign maintNow  = inSop ? kindMaint : pktMaint;
  assign dropNow   = inValid && !inSop && (wordIdx == HOP_IDX) && pktMaint && (hopField == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wordCnt    <= '0;
      pktMaint   <= 1'b0;
      dropActive <= 1'b0;
    end else if (inValid) begin
      // saturate just past the intermediate position so it is hit once
      wordCnt <= (wordIdx == SAT_IDX) ? wordIdx : wordIdx + CNT_W'(1);
      if (inSop) pktMaint <= kindMaint;
      dropActive <= inEop ? 1'b0 : (dropNow | (dropActive & !inSop));
    end
  end

  always_comb begin
    strb.valid   = inValid;
    strb.sop     = inSop;
    strb.eop     = inEop;
    strb.immPos  = inValid && (wordIdx == IMM_IDX);
    strb.hopPos  = inValid && (wordIdx == HOP_IDX);
    strb.maint   = maintNow;
    strb.dropNow = dropNow;
    strb.kill    = inValid && (dropNow || (dropActive && !inSop));
  end

endmodule

// File: rtl/pktcrc_dpath.sv
module pktcrc_dpath
  import pktcrc_pkg::*;
#(
  parameter int HOP_LSB = 24,
  parameter int HOP_W   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [31:0]  inData,
  input  ctrlStrobes_t strb,
  output logic         outValid,
  output logic         outSop,
  output logic         outEop,
  output logic [31:0]  outData,
  output logic         outCrcErr,
  output logic         hopDrop
);

  // receive-side checking
  logic [15:0] rxCrc;
  logic        errAcc;
  logic [15:0] rxSeed;
  logic [15:0] rxHi;
  logic [15:0] rxAll;
  logic        immBad;
  logic        endBad;
  logic        pktErr;
  logic [31:0] modData;

  assign rxSeed = strb.sop ? 16'hFFFF : rxCrc;
  assign rxHi   = crcStep16(rxSeed, inData[31:16]);
  assign rxAll  = crcStep16(rxHi, inData[15:0]);
  assign immBad = strb.immPos && (rxSeed != inData[31:16]);
  assign endBad = strb.eop && (rxHi != inData[15:0]);
  assign pktErr = (strb.sop ? 1'b0 : errAcc) | immBad | endBad;

  always_comb begin
    modData = inData;
    if (strb.maint && strb.hopPos)
      modData[HOP_LSB +: HOP_W] = inData[HOP_LSB +: HOP_W] - HOP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxCrc  <= 16'hFFFF;
      errAcc <= 1'b0;
    end else if (strb.valid) begin
      rxCrc  <= rxAll;
      errAcc <= strb.eop ? 1'b0 : ((strb.sop ? 1'b0 : errAcc) | immBad);
    end
  end

  // stage 1
  logic        s1Valid, s1Sop, s1Eop, s1Imm, s1Maint, s1Err;
  logic [31:0] s1Data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1Sop   <= 1'b0;
      s1Eop   <= 1'b0;
      s1Imm   <= 1'b0;
      s1Maint <= 1'b0;
      s1Err   <= 1'b0;
      s1Data  <= '0;
    end else begin
      s1Valid <= strb.valid && !strb.kill;
      s1Sop   <= strb.sop;
      s1Eop   <= strb.eop;
      s1Imm   <= strb.immPos;
      s1Maint <= strb.maint;
      s1Err   <= pktErr && strb.eop;
      s1Data  <= modData;
    end
  end

  // transmit-side CRC regeneration for maintenance packets
  logic [15:0] txCrc;
  logic [15:0] txSeed;
  logic [15:0] hiOut;
  logic [15:0] txHi;
  logic [15:0] loOut;
  logic [15:0] txAll;

  assign txSeed = s1Sop ? 16'hFFFF : txCrc;
  assign hiOut  = (s1Maint && s1Imm) ? txSeed : s1Data[31:16];
  assign txHi   = crcStep16(txSeed, hiOut);
  assign loOut  = (s1Maint && s1Eop) ? txHi : s1Data[15:0];
  assign txAll  = crcStep16(txHi, loOut);

  always_ff @(posedge clk) begin
    if (rst) txCrc <= 16'hFFFF;
    else if (s1Valid) txCrc <= txAll;
  end

  // stage 2 (output)
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outSop    <= 1'b0;
      outEop    <= 1'b0;
      outData   <= '0;
      outCrcErr <= 1'b0;
      hopDrop   <= 1'b0;
    end else begin
      // a drop decision also removes the first word still held in stage 1
      outValid  <= s1Valid && !strb.dropNow;
      outSop    <= s1Sop;
      outEop    <= s1Eop;
      outData   <= {hiOut, loOut};
      outCrcErr <= s1Valid && !strb.dropNow && s1Err;
      hopDrop   <= strb.dropNow;
    end
  end

endmodule

// File: rtl/pktcrc_fwd.sv
module pktcrc_fwd
  import pktcrc_pkg::*;
#(
  parameter int IMM_BYTES  = 80,
  parameter int KIND_LSB   = 0,
  parameter int KIND_W     = 4,
  parameter int KIND_MAINT = 8,
  parameter int HOP_LSB    = 24,
  parameter int HOP_W      = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inSop,
  input  logic        inEop,
  input  logic [31:0] inData,
  output logic        outValid,
  output logic        outSop,
  output logic        outEop,
  output logic [31:0] outData,
  output logic        outCrcErr,
  output logic        hopDrop
);

  localparam int IMM_WORD = IMM_BYTES / 4;

  ctrlStrobes_t strb;

  pktcrc_ctrl #(
    .IMM_WORD(IMM_WORD), .KIND_W(KIND_W), .KIND_MAINT(KIND_MAINT), .HOP_W(HOP_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .kindField(inData[KIND_LSB +: KIND_W]), .hopField(inData[HOP_LSB +: HOP_W]),
    .strb(strb)
  );

  pktcrc_dpath #(
    .HOP_LSB(HOP_LSB), .HOP_W(HOP_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .inData(inData), .strb(strb),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outData(outData),
    .outCrcErr(outCrcErr), .hopDrop(hopDrop)
  );

endmodule

// File: rtl/pktcrc_fwd_chk.sv
module pktcrc_fwd_chk (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic inSop,
  input logic outValid,
  input logic outSop,
  input logic outEop,
  input logic outCrcErr,
  input logic hopDrop
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!outValid && !hopDrop));

  // R2
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));

  // R2
  sop_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outSop) |-> $past(inSop, 2));

  // R12
  err_on_eop_chk: assert property (@(posedge clk) disable iff (rst)
    outCrcErr |-> (outValid && outEop));

  // R11
  drop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hopDrop |=> !hopDrop);

  // R11
  drop_no_word_chk: assert property (@(posedge clk) disable iff (rst)
    hopDrop |-> !outValid);

endmodule

bind pktcrc_fwd pktcrc_fwd_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop),
  .outValid(outValid), .outSop(outSop), .outEop(outEop),
  .outCrcErr(outCrcErr), .hopDrop(hopDrop)
);

// File: tb/pktcrc_fwd_tb.sv
module pktcrc_fwd_tb;

  localparam int IMMB = 16;
  localparam int IMMW = IMMB / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [31:0] inData = '0;
  logic outValid, outSop, outEop, outCrcErr, hopDrop;
  logic [31:0] outData;

  always #2 clk = ~clk;  // 250 MHz

  pktcrc_fwd #(.IMM_BYTES(IMMB)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inData(inData), .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outData(outData), .outCrcErr(outCrcErr), .hopDrop(hopDrop)
  );

  int checks = 0, errors = 0, cyc = 0;
  int expDrops = 0, gotDrops = 0, pktNo = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] qData[$];
  logic [2:0]  qFlags[$];
  int          qCyc[$];
  string       qTag[$];

  logic [31:0] wk[64];
  logic [31:0] pw[64];

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[15] ^ b[k]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  // insert intermediate and end CRC into wk (R4, R5, R6)
  task automatic stamp(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      if (i == IMMW) wk[i][31:16] = c;
      c = crcByte(c, wk[i][31:24]);
      c = crcByte(c, wk[i][23:16]);
      if (i == n - 1) wk[i][15:0] = c;
      else begin
        c = crcByte(c, wk[i][15:8]);
        c = crcByte(c, wk[i][7:0]);
      end
    end
  endtask

  function automatic bit rxBad(input int n);
    logic [15:0] c = 16'hFFFF;
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      if (i == IMMW && c != wk[i][31:16]) bad = 1;
      c = crcByte(c, wk[i][31:24]);
      c = crcByte(c, wk[i][23:16]);
      if (i == n - 1) begin
        if (c != wk[i][15:0]) bad = 1;
      end else begin
        c = crcByte(c, wk[i][15:8]);
        c = crcByte(c, wk[i][7:0]);
      end
    end
    return bad;
  endfunction

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      inValid = 0; inSop = 0; inEop = 0;
    end
  endtask

  task automatic sendPkt(input int n, input logic [3:0] kind, input logic [7:0] hop,
                         input int cIdx, input logic [31:0] cMask, input string tag);
    bit err, maint, drop;
    pktNo++;
    for (int i = 0; i < n; i++) wk[i] = 32'hA5000000 ^ (pktNo << 8) ^ (i * 32'h01030507);
    wk[0][3:0] = kind;
    if (n > 1) wk[1][31:24] = hop;
    stamp(n);
    wk[cIdx] = wk[cIdx] ^ cMask;
    for (int i = 0; i < n; i++) pw[i] = wk[i];
    err = rxBad(n);
    maint = (kind == 4'h8);
    drop = maint && (hop == 8'd0);
    if (maint && !drop) begin
      wk[1][31:24] = wk[1][31:24] - 8'd1;
      stamp(n);
    end
    if (drop) expDrops++;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inValid = 1; inSop = (i == 0); inEop = (i == n - 1); inData = pw[i];
      if (!drop) begin
        qData.push_back(wk[i]);
        qFlags.push_back({i == 0, i == n - 1, err && (i == n - 1)});
        qCyc.push_back(cyc + 2);
        qTag.push_back(tag);
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (hopDrop) gotDrops++;
      if (outValid) begin
        checks++;
        if (qData.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected word actual=%h expected=none", outData);
        end else begin
          logic [31:0] d; logic [2:0] f; int c; string t;
          d = qData.pop_front(); f = qFlags.pop_front(); c = qCyc.pop_front(); t = qTag.pop_front();
          if (outData !== d || {outSop, outEop, outCrcErr} !== f) begin
            errors++;
            $display("FAIL %s actual=%h sop/eop/err=%b expected=%h %b", t, outData,
                     {outSop, outEop, outCrcErr}, d, f);
          end else if (c != cyc) begin
            errors++;
            $display("FAIL R2 (%s) cycle actual=%0d expected=%0d", t, cyc, c);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1
    if (outValid !== 1'b0 || hopDrop !== 1'b0) begin
      errors++;
      $display("FAIL R1 outValid/hopDrop actual=%b%b expected=00", outValid, hopDrop);
    end
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    checks++;  // R1
    if (outValid !== 1'b0 || hopDrop !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release actual=%b%b expected=00", outValid, hopDrop);
    end
    sendPkt(3, 4'h2, 8'h11, 0, 32'h0, "R3");          // short, end CRC only
    idle(2);
    sendPkt(IMMW, 4'h2, 8'h22, 0, 32'h0, "R7");       // boundary length, no intermediate
    sendPkt(7, 4'h3, 8'h33, 0, 32'h0, "R6");          // both fields, back to back
    idle(1);
    sendPkt(7, 4'h3, 8'h33, IMMW, 32'h0001_0000, "R5"); // intermediate field corrupted
    sendPkt(5, 4'h1, 8'h44, 4, 32'h0000_0001, "R4");    // end field corrupted
    sendPkt(2, 4'h1, 8'h44, 0, 32'h0000_1000, "R4");    // data corrupted, short
    sendPkt(3, 4'h5, 8'h55, 0, 32'h0, "R12");          // clean after error
    idle(3);
    sendPkt(7, 4'h8, 8'h05, 0, 32'h0, "R9");           // maintenance, both fields rebuilt
    sendPkt(3, 4'h8, 8'h01, 2, 32'h0100_0000, "R10");  // maintenance, bad incoming
    idle(2);
    sendPkt(6, 4'h8, 8'h00, 0, 32'h0, "R11");          // hop zero: removed
    sendPkt(4, 4'h9, 8'h00, 0, 32'h0, "R8");           // not maintenance, hop 0 kept
    sendPkt(2, 4'h8, 8'h00, 0, 32'h0, "R11");          // short hop-zero packet
    sendPkt(5, 4'h8, 8'h80, 0, 32'h0, "R9");
    idle(8);
    checks++;  // R2: everything expected came out
    if (qData.size() != 0) begin
      errors++;
      $display("FAIL R2 words left actual=%0d expected=0", qData.size());
    end
    checks++;  // R11
    if (gotDrops != expDrops) begin
      errors++;
      $display("FAIL R11 drop pulses actual=%0d expected=%0d", gotDrops, expDrops);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule